// File: doc/BRIEF.md
# Compare-Match Timer with Write Contention

An 8-bit up-counter advances on falling edges of a selectable count source. The source is one of two prescaled copies of the system clock or an external clock input, and the counter can also be stopped. Two compare registers, A and B, are checked on every count cycle. When the counter equals a compare register, the match sets a sticky flag. A match can also clear the counter and apply a per-channel action (keep, drive low, drive high, toggle) to one waveform output. Software reaches every register over a single-cycle write strobe with address and data, and over a combinational read port.

The block fixes a winner for every case where a software write lands in the same cycle as a hardware event. A clear beats a counter write. A counter write beats an increment. A compare-register write suppresses that channel's match. A flag-set event beats a flag-clearing write. When both channels match in the same cycle, toggle beats drive-high, and drive-high beats drive-low. A count source is switched by plain level selection, so a switch from a high source to a low one counts as a falling edge, just as a real edge does.

Register map: 0 control ([1:0] source: 00 stop, 01 clock/8, 10 clock/64, 11 external; [3:2] clear: 01 on A, 10 on B, 00 or 11 none), 1 actions ([1:0] channel A, [3:2] channel B; 00 keep, 01 low, 10 high, 11 toggle), 2 counter, 3 compare A, 4 compare B, 5 status ([0] match A, [1] match B, [2] overflow). Addresses 6 and 7 read as zero and ignore writes.

Top module: `cmp_timer`

## Requirements
- R1: A count cycle occurs when the selected level was 1 in the previous cycle and is 0 now. The /8 level is bit 2 and the /64 level is bit 5 of a free-running 6-bit prescaler that counts from 0 after reset. In any 64 consecutive cycles with the /8 source, exactly 8 count cycles occur, and each one adds 1 to the counter.
- R2: With source 11, the external input passes through two synchroniser flops, and each 1-to-0 transition of the synchronised level makes one count cycle.
- R3: Switching the source while the old level is 1 and the new level is 0 makes one extra count cycle in the first cycle after the switch.
- R4: An increment from 0xFF gives 0x00 and sets the sticky overflow flag, status bit 2.
- R5: A match happens in a count cycle where the counter equals a compare register. It sets status bit 0 (A) or bit 1 (B). Writing 0 to a status bit clears it. Writing 1 leaves it unchanged. A set event in the same cycle as a clearing write leaves the flag at 1.
- R6: With clear select 01 (or 10), a match on A (or B) loads 0x00 instead of the increment.
- R7: When a clear and a counter write happen in the same cycle, the counter reads 0x00 afterwards.
- R8: When a count cycle and a counter write happen in the same cycle, the counter reads the written value and the increment is lost.
- R9: A write to a compare register in a channel's match cycle suppresses that match: no flag is set, no clear happens and no output action is taken.
- R10: A matching channel applies its action to the waveform output: 00 keep, 01 drive 0, 10 drive 1, 11 toggle. With simultaneous matches, toggle wins over 1, and 1 wins over 0.
- R11: After reset, every register reads 0 and the waveform output is 0.
- R12: Reads return the register map above, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External count source, asynchronous |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | CW | Write data |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | CW | Read data, combinational |
| wave_o | output | 1 | Compare-driven waveform output |

## Verification
A write, a match flag, a clear, an increment and a waveform action all take effect at the rising edge that ends the cycle in which they happen. The bench therefore samples one clock later, at the following falling edge. A switch of the source through the control register produces its extra count one cycle after the write's edge. An external edge reaches the counter three edges after it is driven. A reference model runs in step with the design, and each directed collision uses that model to place the write in exactly the predicted count cycle. The register of interest is then read back right after that edge.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        A_CTRL = 3'd0,
        A_ACT  = 3'd1,
        A_CNT  = 3'd2,
        A_CMPA = 3'd3,
        A_CMPB = 3'd4,
        A_STAT = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_STOP   = 2'd0,
        SRC_DIV_LO = 2'd1,
        SRC_DIV_HI = 2'd2,
        SRC_EXT    = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'd0,
        CLR_ON_A = 2'd1,
        CLR_ON_B = 2'd2,
        CLR_RSVD = 2'd3
    } clr_sel_e;

    // numeric order equals priority: higher code wins
    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_TOG  = 2'd3
    } act_e;

endpackage

// File: rtl/cmt_clk_src.sv
module cmt_clk_src
    import cmt_pkg::*;
#(
    parameter int DIV_LO_LOG2 = 3,
    parameter int DIV_HI_LOG2 = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  src_sel_e sel_i,
    input  logic     ext_clk_i,
    output logic     tick_o
);
    localparam int PW = DIV_HI_LOG2;

    typedef struct packed {
        logic [PW-1:0]          presc;
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } src_state_t;

    src_state_t s_q, s_d;
    logic       level;

    always_comb begin
        unique case (sel_i)
            SRC_STOP:   level = 1'b0;
            SRC_DIV_LO: level = s_q.presc[DIV_LO_LOG2-1];
            SRC_DIV_HI: level = s_q.presc[PW-1];
            default:    level = s_q.sync[SYNC_STAGES-1];
        endcase
        s_d.presc = s_q.presc + 1'b1;
        s_d.sync  = {s_q.sync[SYNC_STAGES-2:0], ext_clk_i};
        // history of the selected level, not of one source: a switch
        // from a high source to a low one is seen as a falling edge
        s_d.prev  = level;
        tick_o    = s_q.prev & ~level;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

endmodule

// File: rtl/cmt_out_ctl.sv
module cmt_out_ctl
    import cmt_pkg::*;
(
    input  logic hit_a_i,
    input  logic hit_b_i,
    input  act_e act_a_i,
    input  act_e act_b_i,
    input  logic wave_i,
    output logic wave_d_o
);
    act_e eff_a, eff_b, win;

    always_comb begin
        eff_a = hit_a_i ? act_a_i : ACT_KEEP;
        eff_b = hit_b_i ? act_b_i : ACT_KEEP;
        win   = (eff_a > eff_b) ? eff_a : eff_b;
        unique case (win)
            ACT_KEEP: wave_d_o = wave_i;
            ACT_LOW:  wave_d_o = 1'b0;
            ACT_HIGH: wave_d_o = 1'b1;
            default:  wave_d_o = ~wave_i;
        endcase
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmt_pkg::*;
#(
    parameter int CW          = 8,
    parameter int DIV_LO_LOG2 = 3,
    parameter int DIV_HI_LOG2 = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ext_clk_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [CW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [CW-1:0] rd_data_o,
    output logic          wave_o
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        src_sel_e      src;
        clr_sel_e      clr;
        act_e          act_a;
        act_e          act_b;
        logic [CW-1:0] cnt;
        logic [CW-1:0] cmp_a;
        logic [CW-1:0] cmp_b;
        logic          flag_a;
        logic          flag_b;
        logic          flag_ovf;
        logic          wave;
    } tmr_state_t;

    tmr_state_t st_q, st_d;
    logic tick, hit_a, hit_b, clr_evt, wave_nxt;
    logic wr_ctrl, wr_act, wr_cnt, wr_cmpa, wr_cmpb, wr_stat;

    cmt_clk_src #(
        .DIV_LO_LOG2(DIV_LO_LOG2),
        .DIV_HI_LOG2(DIV_HI_LOG2),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_src (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sel_i     (st_q.src),
        .ext_clk_i (ext_clk_i),
        .tick_o    (tick)
    );

    cmt_out_ctl u_out (
        .hit_a_i  (hit_a),
        .hit_b_i  (hit_b),
        .act_a_i  (st_q.act_a),
        .act_b_i  (st_q.act_b),
        .wave_i   (st_q.wave),
        .wave_d_o (wave_nxt)
    );

    always_comb begin
        wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
        wr_act  = wr_en_i && (wr_addr_i == A_ACT);
        wr_cnt  = wr_en_i && (wr_addr_i == A_CNT);
        wr_cmpa = wr_en_i && (wr_addr_i == A_CMPA);
        wr_cmpb = wr_en_i && (wr_addr_i == A_CMPB);
        wr_stat = wr_en_i && (wr_addr_i == A_STAT);

        // a compare register write masks its own channel for this cycle
        hit_a   = tick && (st_q.cnt == st_q.cmp_a) && !wr_cmpa;
        hit_b   = tick && (st_q.cnt == st_q.cmp_b) && !wr_cmpb;
        clr_evt = ((st_q.clr == CLR_ON_A) && hit_a) ||
                  ((st_q.clr == CLR_ON_B) && hit_b);

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.src = src_sel_e'(wr_data_i[1:0]);
            st_d.clr = clr_sel_e'(wr_data_i[3:2]);
        end
        if (wr_act) begin
            st_d.act_a = act_e'(wr_data_i[1:0]);
            st_d.act_b = act_e'(wr_data_i[3:2]);
        end
        if (wr_cmpa) st_d.cmp_a = wr_data_i;
        if (wr_cmpb) st_d.cmp_b = wr_data_i;

        // clearing writes first, hardware set events override them
        if (wr_stat) begin
            if (!wr_data_i[0]) st_d.flag_a   = 1'b0;
            if (!wr_data_i[1]) st_d.flag_b   = 1'b0;
            if (!wr_data_i[2]) st_d.flag_ovf = 1'b0;
        end
        if (hit_a) st_d.flag_a = 1'b1;
        if (hit_b) st_d.flag_b = 1'b1;

        // counter: clear > write > increment
        if (clr_evt) begin
            st_d.cnt = '0;
        end else if (wr_cnt) begin
            st_d.cnt = wr_data_i;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_MAX) st_d.flag_ovf = 1'b1;
        end

        st_d.wave = wave_nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            A_CTRL: rd_data_o[3:0] = {st_q.clr, st_q.src};
            A_ACT:  rd_data_o[3:0] = {st_q.act_b, st_q.act_a};
            A_CNT:  rd_data_o      = st_q.cnt;
            A_CMPA: rd_data_o      = st_q.cmp_a;
            A_CMPB: rd_data_o      = st_q.cmp_b;
            A_STAT: rd_data_o[2:0] = {st_q.flag_ovf, st_q.flag_b, st_q.flag_a};
            default: rd_data_o     = '0;
        endcase
    end

    assign wave_o = st_q.wave;

endmodule

// File: rtl/cmt_checker.sv
module cmt_checker
    import cmt_pkg::*;
#(
    parameter int CW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          wr_en_i,
    input logic [AW-1:0] wr_addr_i,
    input logic [CW-1:0] wr_data_i,
    input logic          wave_o,
    input logic          tick,
    input logic          hit_a,
    input logic          clr_evt,
    input logic [CW-1:0] cnt_q,
    input logic          flag_a,
    input logic          flag_ovf,
    input logic [1:0]    act_a
);
    logic wr_cnt_c;
    assign wr_cnt_c = wr_en_i && (wr_addr_i == A_CNT);

    AST_INC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && !clr_evt && !wr_cnt_c) |=> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R1

    AST_WRAP_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && (cnt_q == '1) && !clr_evt && !wr_cnt_c) |=> (cnt_q == '0 && flag_ovf)); // R4

    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_a |=> flag_a); // R5

    AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_evt |=> (cnt_q == '0)); // R7

    AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_cnt_c && !clr_evt) |=> (cnt_q == $past(wr_data_i))); // R8

    AST_CMP_WR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_addr_i == A_CMPA) && !flag_a) |=> !flag_a); // R9

    AST_TOGGLE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_a && (act_a == 2'b11)) |=> (wave_o != $past(wave_o))); // R10

endmodule

bind cmp_timer cmt_checker #(.CW(CW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wave_o    (wave_o),
    .tick      (tick),
    .hit_a     (hit_a),
    .clr_evt   (clr_evt),
    .cnt_q     (st_q.cnt),
    .flag_a    (st_q.flag_a),
    .flag_ovf  (st_q.flag_ovf),
    .act_a     (st_q.act_a)
);

// File: tb/tb_cmp_timer.sv
module tb_cmp_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_r = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wave;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer dut (
        .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_r),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .wave_o(wave)
    );

    // reference model state
    logic [5:0] m_presc = '0;
    logic [1:0] m_sy = '0;
    logic       m_prev = 1'b0;
    logic [1:0] m_csel = '0, m_clr = '0, m_aa = '0, m_ab = '0;
    logic [7:0] m_cnt = '0, m_ca = '0, m_cb = '0;
    logic       m_fa = 1'b0, m_fb = 1'b0, m_fo = 1'b0, m_wave = 1'b0;

    function automatic logic m_level();
        case (m_csel)
            2'd0: return 1'b0;
            2'd1: return m_presc[2];
            2'd2: return m_presc[5];
            default: return m_sy[1];
        endcase
    endfunction

    function automatic logic m_tick();
        return m_prev & ~m_level();
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {4'b0, m_clr, m_csel};
            3'd1: return {4'b0, m_ab, m_aa};
            3'd2: return m_cnt;
            3'd3: return m_ca;
            3'd4: return m_cb;
            3'd5: return {5'b0, m_fo, m_fb, m_fa};
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_step(input logic we, input logic [2:0] ad, input logic [7:0] d);
        logic lvl, t, ha, hb, clr;
        logic [1:0] ea, eb, w;
        lvl = m_level();
        t   = m_prev & ~lvl;
        ha  = t && (m_cnt == m_ca) && !(we && ad == 3'd3);
        hb  = t && (m_cnt == m_cb) && !(we && ad == 3'd4);
        clr = (m_clr == 2'd1 && ha) || (m_clr == 2'd2 && hb);
        ea  = ha ? m_aa : 2'd0;
        eb  = hb ? m_ab : 2'd0;
        w   = (ea > eb) ? ea : eb;
        case (w)
            2'd1: m_wave = 1'b0;
            2'd2: m_wave = 1'b1;
            2'd3: m_wave = ~m_wave;
            default: ;
        endcase
        if (we && ad == 3'd5) begin
            if (!d[0]) m_fa = 1'b0;
            if (!d[1]) m_fb = 1'b0;
            if (!d[2]) m_fo = 1'b0;
        end
        if (ha) m_fa = 1'b1;
        if (hb) m_fb = 1'b1;
        if (clr) m_cnt = 8'h00;
        else if (we && ad == 3'd2) m_cnt = d;
        else if (t) begin
            if (m_cnt == 8'hFF) m_fo = 1'b1;
            m_cnt = m_cnt + 8'd1;
        end
        if (we && ad == 3'd0) begin m_csel = d[1:0]; m_clr = d[3:2]; end
        if (we && ad == 3'd1) begin m_aa = d[1:0]; m_ab = d[3:2]; end
        if (we && ad == 3'd3) m_ca = d;
        if (we && ad == 3'd4) m_cb = d;
        m_prev  = lvl;
        m_sy    = {m_sy[0], ext_r};
        m_presc = m_presc + 6'd1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd2: return "R1";
            3'd5: return "R5";
            default: return "R12";
        endcase
    endfunction

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    // one clock: compare against the model, drive, advance both
    task automatic cycle(input logic we, input logic [2:0] ad, input logic [7:0] d);
        logic [2:0] ra;
        ra = 3'($urandom_range(0, 7));
        rd_addr = ra;
        #1;
        chk(tag_of(ra), rd_data, m_read(ra));
        chk("R10", {7'b0, wave}, {7'b0, m_wave});
        wr_en = we; wr_addr = ad; wr_data = d;
        m_step(we, ad, d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 3'd0, 8'h00);
    endtask

    task automatic wait_tick();
        while (!m_tick()) cycle(1'b0, 3'd0, 8'h00);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] w0;
        logic [5:0] p;
        int seed;
        seed = 20240611;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        for (int a = 0; a < 8; a++) expect_reg(3'(a), 8'h00, "R11 reset value");
        chk("R11 reset wave", {7'b0, wave}, 8'h00);
        rst_n = 1'b1;

        // compare registers away from the counting range
        cycle(1'b1, 3'd3, 8'hF0);
        cycle(1'b1, 3'd4, 8'hF0);

        // R1: /8 source gives 8 counts per 64 cycles
        cycle(1'b1, 3'd0, 8'h01);
        idle(5);
        cycle(1'b1, 3'd2, 8'h00);
        idle(64);
        expect_reg(3'd2, 8'h08, "R1 eight counts in 64 cycles");

        // R8: write in a count cycle wins
        wait_tick();
        cycle(1'b1, 3'd2, 8'h55);
        expect_reg(3'd2, 8'h55, "R8 write beats increment");

        // R7/R6: clear on A collides with a counter write
        cycle(1'b1, 3'd0, 8'h05);
        cycle(1'b1, 3'd3, 8'h60);
        cycle(1'b1, 3'd5, 8'h00);
        cycle(1'b1, 3'd2, 8'h60);
        wait_tick();
        cycle(1'b1, 3'd2, 8'h33);
        expect_reg(3'd2, 8'h00, "R7 clear beats write");
        expect_reg(3'd5, 8'h01, "R5 flag A set by match");

        // R5: clearing write, then set beats clear
        cycle(1'b1, 3'd5, 8'h00);
        expect_reg(3'd5, 8'h00, "R5 write 0 clears flag");
        cycle(1'b1, 3'd2, 8'h60);
        wait_tick();
        cycle(1'b1, 3'd5, 8'h00);
        expect_reg(3'd5, 8'h01, "R5 set beats clearing write");
        expect_reg(3'd2, 8'h00, "R6 clear on A");

        // R9: compare write suppresses the match
        cycle(1'b1, 3'd0, 8'h01);
        cycle(1'b1, 3'd3, 8'h70);
        cycle(1'b1, 3'd5, 8'h00);
        cycle(1'b1, 3'd2, 8'h70);
        wait_tick();
        cycle(1'b1, 3'd3, 8'h70);
        expect_reg(3'd5, 8'h00, "R9 match suppressed");
        expect_reg(3'd2, 8'h71, "R9 count continues");

        // R4: wrap and overflow
        cycle(1'b1, 3'd2, 8'hFF);
        cycle(1'b1, 3'd5, 8'h00);
        wait_tick();
        cycle(1'b0, 3'd0, 8'h00);
        expect_reg(3'd2, 8'h00, "R4 wrap to zero");
        expect_reg(3'd5, 8'h04, "R4 overflow flag");

        // R10: simultaneous matches, toggle beats high
        cycle(1'b1, 3'd1, 8'h0B);
        cycle(1'b1, 3'd3, 8'h20);
        cycle(1'b1, 3'd4, 8'h20);
        cycle(1'b1, 3'd2, 8'h20);
        wait_tick();
        w0 = {7'b0, wave};
        cycle(1'b0, 3'd0, 8'h00);
        chk("R10 toggle beats high", {7'b0, wave}, {7'b0, ~w0[0]});
        // high beats low
        cycle(1'b1, 3'd1, 8'h09);
        cycle(1'b1, 3'd2, 8'h20);
        wait_tick();
        cycle(1'b0, 3'd0, 8'h00);
        chk("R10 high beats low", {7'b0, wave}, 8'h01);
        // low alone
        cycle(1'b1, 3'd1, 8'h01);
        cycle(1'b1, 3'd2, 8'h20);
        wait_tick();
        cycle(1'b0, 3'd0, 8'h00);
        chk("R10 drive low", {7'b0, wave}, 8'h00);

        // R3: switch /8 (high) to /64 (low) gives one count
        cycle(1'b1, 3'd1, 8'h00);
        p = m_presc + 6'd1;
        while (!(p[2] && !p[5] && p[4:0] != 5'd31)) begin
            cycle(1'b0, 3'd0, 8'h00);
            p = m_presc + 6'd1;
        end
        cycle(1'b1, 3'd2, 8'h10);
        cycle(1'b1, 3'd0, 8'h02);
        cycle(1'b0, 3'd0, 8'h00);
        expect_reg(3'd2, 8'h11, "R3 switch counts as falling edge");

        // R2: one external pulse is one count
        ext_r = 1'b0;
        cycle(1'b1, 3'd0, 8'h03);
        idle(4);
        cycle(1'b1, 3'd2, 8'h00);
        ext_r = 1'b1;
        idle(5);
        ext_r = 1'b0;
        idle(5);
        expect_reg(3'd2, 8'h01, "R2 external falling edge");

        // mixed random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) ext_r = ~ext_r;
            if ($urandom_range(0, 9) < 3)
                cycle(1'b1, 3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)));
            else
                cycle(1'b0, 3'd0, 8'h00);
        end

        finish_run();
    end

endmodule